// File: doc/BRIEF.md
# Four-Quadrant Batch Mosaic Writer

This block stitches a batch of four equally sized images into one frame of twice the height and twice the width, laid out as a 2x2 mosaic. Downstream, a single convolution engine then treats the batch as one larger input. Because it works on the whole mosaic at once, it needs only one weight fetch from external memory for all four images. The shared on-chip feature buffer also keeps one fixed size for every layer.

Pixels arrive as a raster stream. Each pixel carries an image index, a start-of-image marker and an end-of-image marker. For every accepted pixel, the block emits a registered write to the feature buffer: the row-major address inside the stitched frame, together with the pixel value. When the last pixel of the fourth image has been written, it raises a one-cycle done pulse. Any pixel that breaks the expected order is dropped and recorded in a sticky error flag.

Top module: `mosaic_stitcher`

## Requirements
- R1: While reset is held and right after it, wr_en_o, done_o and err_o are 0.
- R2: A pixel of image k (index 0 to 3) at local row r, column c is written to address (r + (k>>1)*IMG_H) * 2*IMG_W + c + (k&1)*IMG_W.
- R3: Inside an image, the local column counts 0 to IMG_W-1 and then wraps to column 0 of the next row.
- R4: Images are accepted strictly in the order 0, 1, 2, 3. An accepted pixel with pix_eof_i set ends the current image, and the next expected index is the following one.
- R5: done_o is high for exactly one cycle, in the cycle after the write of the image-3 end pixel appears on the write port.
- R6: A pixel presented in the cycle after the image-3 end pixel is accepted gets no write and sets err_o. From the done cycle onward, image 0 of a new batch is accepted.
- R7: A valid pixel whose index differs from the expected index gets no write and sets err_o. err_o then stays 1 until reset.
- R8: An accepted pixel with pix_sof_i set is written at local row 0, column 0, and the position counting restarts from there.
- R9: Once an image has received IMG_H*IMG_W pixels without an end marker, further pixels without pix_sof_i get no write and set err_o.
- R10: Each accepted pixel appears on the write port one cycle after it is sampled, with wr_data_o equal to pix_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel present this cycle |
| pix_img_i | input | 2 | Batch index of the pixel's image |
| pix_data_i | input | PIX_W | Fixed-point pixel value |
| pix_sof_i | input | 1 | First pixel of an image |
| pix_eof_i | input | 1 | Last pixel of an image |
| wr_en_o | output | 1 | Feature buffer write strobe |
| wr_addr_o | output | ADDR_W | Row-major address in the stitched frame |
| wr_data_o | output | PIX_W | Value to write |
| done_o | output | 1 | Batch of four images complete |
| err_o | output | 1 | Sticky flag for a dropped pixel |

## Verification
The bench builds the block with IMG_H=3, IMG_W=4 and PIX_W=9. With these values a full batch is 48 pixels, so the bench can drive many complete batches. Every quadrant corner, every column wrap and the overfill limit of R9 are reached within a few dozen cycles. The 9-bit width keeps the data path at its intended size, which lets the bench check pixel values across the full code range.

// File: rtl/mosaic_pkg.sv
package mosaic_pkg;
  typedef enum logic {ST_RUN, ST_FIN} stitch_state_e;
  localparam int unsigned NUM_IMG = 4;
endpackage

// File: rtl/mosaic_seq_ctrl.sv
module mosaic_seq_ctrl
  import mosaic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_valid_i,
  input  logic [1:0] pix_img_i,
  input  logic       pix_eof_i,
  input  logic       pos_ok_i,
  output logic       accept_o,
  output logic       done_o,
  output logic       err_o
);
  stitch_state_e state_q;
  logic [1:0]    exp_img_q;
  logic          done_q, err_q;

  assign accept_o = pix_valid_i && (state_q == ST_RUN) && (pix_img_i == exp_img_q) && pos_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      exp_img_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIN);
      if (pix_valid_i && !accept_o) err_q <= 1'b1;
      if (state_q == ST_FIN) begin
        state_q   <= ST_RUN;
        exp_img_q <= '0;
      end else if (accept_o && pix_eof_i) begin
        if (exp_img_q == 2'(NUM_IMG - 1)) state_q <= ST_FIN;
        else exp_img_q <= exp_img_q + 2'd1;
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) err_q |=> err_q);
endmodule

// File: rtl/mosaic_pos_cnt.sv
module mosaic_pos_cnt #(
  parameter int unsigned IMG_H = 160,
  parameter int unsigned IMG_W = 320,
  localparam int unsigned ROW_W = $clog2(IMG_H + 1),
  localparam int unsigned COL_W = $clog2(IMG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             accept_i,
  output logic             pos_ok_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  // start marker overrides stored position
  assign row_o    = sof_i ? '0 : row_q;
  assign col_o    = sof_i ? '0 : col_q;
  assign pos_ok_o = sof_i || (row_q < ROW_W'(IMG_H));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept_i) begin
      if (eof_i) begin
        row_q <= '0;
        col_q <= '0;
      end else if (col_o == COL_W'(IMG_W - 1)) begin
        row_q <= row_o + ROW_W'(1);
        col_q <= '0;
      end else begin
        row_q <= row_o;
        col_q <= col_o + COL_W'(1);
      end
    end
  end

  a_r9_row_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) row_q <= ROW_W'(IMG_H));
endmodule

// File: rtl/mosaic_addr_gen.sv
module mosaic_addr_gen #(
  parameter int unsigned IMG_H = 160,
  parameter int unsigned IMG_W = 320,
  localparam int unsigned ROW_W  = $clog2(IMG_H + 1),
  localparam int unsigned COL_W  = $clog2(IMG_W),
  localparam int unsigned ADDR_W = $clog2(4 * IMG_H * IMG_W)
) (
  input  logic [1:0]        img_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base [4];

  for (genvar k = 0; k < 4; k++) begin : g_quad
    localparam int unsigned QROW = (k / 2) * IMG_H;
    localparam int unsigned QCOL = (k % 2) * IMG_W;
    assign base[k] = ADDR_W'(QROW * 2 * IMG_W + QCOL);
  end

  assign addr_o = base[img_i] + ADDR_W'(row_i) * ADDR_W'(2 * IMG_W) + ADDR_W'(col_i);
endmodule

// File: rtl/mosaic_stitcher.sv
module mosaic_stitcher #(
  parameter int unsigned PIX_W = 9,
  parameter int unsigned IMG_H = 160,
  parameter int unsigned IMG_W = 320,
  localparam int unsigned ROW_W  = $clog2(IMG_H + 1),
  localparam int unsigned COL_W  = $clog2(IMG_W),
  localparam int unsigned ADDR_W = $clog2(4 * IMG_H * IMG_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic [1:0]        pix_img_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic              pix_sof_i,
  input  logic              pix_eof_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [PIX_W-1:0]  wr_data_o,
  output logic              done_o,
  output logic              err_o
);
  logic             accept, pos_ok;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [ADDR_W-1:0] addr;

  mosaic_seq_ctrl u_seq (
    .clk_i, .rst_ni, .pix_valid_i, .pix_img_i, .pix_eof_i,
    .pos_ok_i(pos_ok), .accept_o(accept), .done_o, .err_o
  );

  mosaic_pos_cnt #(.IMG_H(IMG_H), .IMG_W(IMG_W)) u_pos (
    .clk_i, .rst_ni, .sof_i(pix_sof_i), .eof_i(pix_eof_i),
    .accept_i(accept), .pos_ok_o(pos_ok), .row_o(row), .col_o(col)
  );

  mosaic_addr_gen #(.IMG_H(IMG_H), .IMG_W(IMG_W)) u_addr (
    .img_i(pix_img_i), .row_i(row), .col_i(col), .addr_o(addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= accept;
      if (accept) begin
        wr_addr_o <= addr;
        wr_data_o <= pix_data_i;
      end
    end
  end

  a_r2_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ({1'b0, wr_addr_o} < (ADDR_W+1)'(4 * IMG_H * IMG_W)));
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  a_r6_no_write_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> !wr_en_o);
endmodule

// File: tb/mosaic_stitcher_bench.sv
module mosaic_stitcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 9;
  localparam int H  = 3;
  localparam int W  = 4;
  localparam int AW = $clog2(4 * H * W);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pv = 1'b0, ps = 1'b0, pe = 1'b0;
  logic [1:0] pi = '0;
  logic [PW-1:0] pd = '0;
  logic wr_en, done, err;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_data;

  int checks = 0, errors = 0, cycles = 0;
  bit m_fin, m_err;
  int m_exp, m_row, m_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  mosaic_stitcher #(.PIX_W(PW), .IMG_H(H), .IMG_W(W)) u_mosaic_stitcher (
    .clk_i(clk), .rst_ni(rst_ni), .pix_valid_i(pv), .pix_img_i(pi), .pix_data_i(pd),
    .pix_sof_i(ps), .pix_eof_i(pe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .done_o(done), .err_o(err)
  );

  function automatic int ref_addr(int k, int r, int c);
    return (r + (k / 2) * H) * 2 * W + c + (k % 2) * W;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; pv = 0; ps = 0; pe = 0;
    @(negedge clk);
    chk("R1 wr_en", wr_en, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_fin = 0; m_err = 0; m_exp = 0; m_row = 0; m_col = 0;
  endtask

  task automatic step(string tag, bit v, int im, int d, bit s, bit e);
    bit e_we = 0, e_done;
    int e_addr = 0, r, c;
    e_done = m_fin;
    if (m_fin) begin
      if (v) m_err = 1;
      m_fin = 0; m_exp = 0;
    end else if (v) begin
      if (im == m_exp && (s || m_row < H)) begin
        r = s ? 0 : m_row; c = s ? 0 : m_col;
        e_we = 1; e_addr = ref_addr(im, r, c);
        if (e) begin
          m_row = 0; m_col = 0;
          if (m_exp == 3) m_fin = 1; else m_exp++;
        end else if (c == W - 1) begin m_row = r + 1; m_col = 0; end
        else begin m_row = r; m_col = c + 1; end
      end else m_err = 1;
    end
    pv = v; pi = im[1:0]; pd = d[PW-1:0]; ps = s; pe = e;
    @(negedge clk);
    pv = 0;
    chk({tag, " wr_en"}, wr_en, e_we);
    if (e_we) begin
      chk("R2 R3 addr", wr_addr, e_addr);
      chk("R10 data", wr_data, d % (1 << PW));
    end
    chk("R5 done", done, e_done);
    chk({tag, " err"}, err, m_err);
  endtask

  task automatic send_image(string tag, int k);
    for (int p = 0; p < H * W; p++)
      step(tag, 1, k, $urandom_range(0, (1 << PW) - 1), p == 0, p == H * W - 1);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual %0d expected below %0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // full ordered batch, all quadrants
    for (int k = 0; k < 4; k++) send_image("R4", k);
    step("R5", 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0);
    // second batch back-to-back, pixel during the finishing cycle
    for (int k = 0; k < 4; k++) send_image("R4", k);
    step("R6", 1, 0, 5, 1, 0);
    step("R6", 1, 0, 6, 1, 0);
    step("R6", 1, 0, 7, 0, 0);
    do_reset();
    // restart marker mid-image
    for (int p = 0; p < 5; p++) step("R3", 1, 0, p, p == 0, 0);
    step("R8", 1, 0, 99, 1, 0);
    step("R8", 1, 0, 98, 0, 0);
    chk("R8 err", err, 0);
    do_reset();
    // overfill without end marker
    for (int p = 0; p < H * W; p++) step("R9", 1, 0, p, p == 0, 0);
    step("R9", 1, 0, 77, 0, 0);
    do_reset();
    // wrong index, then sticky flag
    step("R7", 1, 2, 11, 1, 0);
    step("R7", 1, 0, 12, 1, 0);
    step("R7", 1, 0, 13, 0, 1);
    step("R7", 1, 1, 14, 1, 0);
    do_reset();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit v, s, e;
      int im;
      if (n % 1000 == 999) do_reset();
      v  = ($urandom_range(0, 9) != 0);
      im = ($urandom_range(0, 19) == 0) ? $urandom_range(0, 3) : m_exp;
      s  = (m_row == 0 && m_col == 0) || ($urandom_range(0, 49) == 0);
      e  = (m_row == H - 1 && m_col == W - 1) || ($urandom_range(0, 29) == 0);
      step("R4", v, im, $urandom_range(0, (1 << PW) - 1), s, e);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule